// File: doc/BRIEF.md
# GPIO Port Pad-Resolution Datapath

This block is one general-purpose I/O port of up to 32 pins, driven from a simple single-cycle register bus. Software sets the output value, output enable, push-pull or open-drain mode, polarity, pull-up, pull-down and input mask for each pin. The output value and the output enable each have a set alias and a clear alias, so single pins can change without a read-modify-write.

Inside the block, a per-pin pad model works out the level on each pin. The level comes from the driver, from the open-drain release and from the pulls. The model then forms the data-in readback through the input mask and the input polarity.

A two-key temporary lock protects every control register. Any write to a lock register closes the lock. Only a fixed key pair, written in the right order, opens it again.

Top module: `gpio_pad_port`

## Requirements
- R1: A pin with output enable 1 and output type 0 (push-pull) sits at data-out XOR polarity.
- R2: A pin with output enable 1 and output type 1 (open-drain) is driven low when data-out XOR polarity is 0. When that value is 1, the pin is released and takes its pull level.
- R3: An undriven pin sits at 1 when only its pull-up bit is set, and at 0 when only its pull-down bit is set.
- R4: An undriven pin sits at 0 when both of its pull bits are set, and also when neither is set.
- R5: Data-in bit i reads as (pin level AND input-mask bit) XOR polarity bit. A masked-off pin therefore reads back its polarity bit.
- R6: A write to a set alias ORs the written bits into its register. A write to a clear alias clears the written bits in its register. Both rules hold for data out and for output enable.
- R7: The lock register at address 0 reads 0 when the port is unlocked and 1 otherwise. Any write to address 0 or to address 13 leaves the port locked, except the final step of the unlock sequence.
- R8: The port unlocks only in one way. 0xC0DE1248 is written to address 13, and the next lock-register write puts 0xC0DEFA73 at address 0. Any other order or value leaves the port locked.
- R9: While the port is locked, writes to every control register and alias are ignored and the old values are kept. Reads still return current values.
- R10: After reset the port is unlocked. Data out, output enable, output type, polarity and pull-down are all 0. Pull-up and the input mask are all 1.
- R11: A read request is answered with bus_rvalid high exactly one cycle later; a write produces no response. The word address map is as follows. Address 0 is lock status and the final key. Address 1 is data in and is read-only. Addresses 2, 3 and 4 are data out and its set and clear aliases. Addresses 5, 6 and 7 are output enable and its set and clear aliases. Address 8 is output type, 9 is polarity, 10 is pull-up, 11 is pull-down and 12 is the input mask. Address 13 takes the arming key. Aliases, address 13 and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |

## Verification
The hardest state to reach from the ports is the armed-but-still-locked state. The first key has been taken, but a control write must still be dropped, and the next lock write decides the outcome. The stimulus reaches it in three ways:
- the two keys in reversed order;
- the arming key followed by a wrong final key;
- the arming key, then a locked data-out write, then the final key.

Each of these is followed by a read of the lock status and of the data-out register. Open-drain release combined with inverted polarity is reached by setting output type, output enable and polarity together. Pull patterns with mixed bits cover pins that are driven low, pins that are released high and pins that are released low, all in one data-in read.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

   localparam int BUS_W  = 32;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      REG_LOCK_A   = 4'd0,
      REG_DIN      = 4'd1,
      REG_DOUT     = 4'd2,
      REG_DOUT_SET = 4'd3,
      REG_DOUT_CLR = 4'd4,
      REG_OE       = 4'd5,
      REG_OE_SET   = 4'd6,
      REG_OE_CLR   = 4'd7,
      REG_OTYPE    = 4'd8,
      REG_POL      = 4'd9,
      REG_PULLUP   = 4'd10,
      REG_PULLDN   = 4'd11,
      REG_INMASK   = 4'd12,
      REG_LOCK_B   = 4'd13
   } reg_sel_e;

   typedef enum logic [1:0] {
      LK_OPEN  = 2'd0,
      LK_SHUT  = 2'd1,
      LK_ARMED = 2'd2
   } lock_state_e;

endpackage

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
   import gpio_pad_pkg::*;
#(
   parameter logic [BUS_W-1:0] KEY_ARM  = 32'hC0DE1248,
   parameter logic [BUS_W-1:0] KEY_OPEN = 32'hC0DEFA73
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_a,
   input  logic             wr_b,
   input  logic [BUS_W-1:0] wdata,
   output logic             locked
);

   lock_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (wr_b) begin
         state_d = (wdata == KEY_ARM) ? LK_ARMED : LK_SHUT;
      end else if (wr_a) begin
         state_d = (state_q == LK_ARMED && wdata == KEY_OPEN) ? LK_OPEN : LK_SHUT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LK_OPEN;
      else        state_q <= state_d;
   end

   assign locked = (state_q != LK_OPEN);

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
   import gpio_pad_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  dout_q,
   output logic [WIDTH-1:0]  oe_q,
   output logic [WIDTH-1:0]  otype_q,
   output logic [WIDTH-1:0]  pol_q,
   output logic [WIDTH-1:0]  pu_q,
   output logic [WIDTH-1:0]  pd_q,
   output logic [WIDTH-1:0]  mask_q
);

   localparam logic [WIDTH-1:0] ALL_ZERO = '0;
   localparam logic [WIDTH-1:0] ALL_ONE  = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q  <= ALL_ZERO;
         oe_q    <= ALL_ZERO;
         otype_q <= ALL_ZERO;
         pol_q   <= ALL_ZERO;
         pu_q    <= ALL_ONE;
         pd_q    <= ALL_ZERO;
         mask_q  <= ALL_ONE;
      end else if (wr_en) begin
         case (reg_sel_e'(addr))
            REG_DOUT:     dout_q  <= wdata;
            REG_DOUT_SET: dout_q  <= dout_q | wdata;
            REG_DOUT_CLR: dout_q  <= dout_q & ~wdata;
            REG_OE:       oe_q    <= wdata;
            REG_OE_SET:   oe_q    <= oe_q | wdata;
            REG_OE_CLR:   oe_q    <= oe_q & ~wdata;
            REG_OTYPE:    otype_q <= wdata;
            REG_POL:      pol_q   <= wdata;
            REG_PULLUP:   pu_q    <= wdata;
            REG_PULLDN:   pd_q    <= wdata;
            REG_INMASK:   mask_q  <= wdata;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/gpio_pad_resolve.sv
module gpio_pad_resolve #(
   parameter int WIDTH          = 32,
   parameter bit HAS_OPEN_DRAIN = 1'b1
) (
   input  logic [WIDTH-1:0] dout,
   input  logic [WIDTH-1:0] oe,
   input  logic [WIDTH-1:0] otype,
   input  logic [WIDTH-1:0] pol,
   input  logic [WIDTH-1:0] pu,
   input  logic [WIDTH-1:0] pd,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] pin,
   output logic [WIDTH-1:0] din
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic outv;
      logic drive;
      logic pull_lvl;

      assign outv     = dout[i] ^ pol[i];
      assign pull_lvl = pu[i] & ~pd[i];

      if (HAS_OPEN_DRAIN) begin : g_od
         assign drive = oe[i] & (~otype[i] | ~outv);
      end else begin : g_pp
         logic unused_type;
         assign unused_type = otype[i];
         assign drive = oe[i];
      end

      assign pin[i] = drive ? outv : pull_lvl;
      assign din[i] = (pin[i] & mask[i]) ^ pol[i];
   end

endmodule

// File: rtl/gpio_pad_port.sv
module gpio_pad_port
   import gpio_pad_pkg::*;
#(
   parameter int               WIDTH          = 32,
   parameter bit               HAS_OPEN_DRAIN = 1'b1,
   parameter logic [BUS_W-1:0] KEY_ARM        = 32'hC0DE1248,
   parameter logic [BUS_W-1:0] KEY_OPEN       = 32'hC0DEFA73
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic              bus_rvalid,
   output logic [BUS_W-1:0]  bus_rdata
);

   if (WIDTH < 1 || WIDTH > BUS_W) begin : g_bad_width
      $error("gpio_pad_port: WIDTH must lie in 1..BUS_W");
   end

   logic             wr_any, wr_lock_a, wr_lock_b, wr_ctrl, rd_any;
   logic             locked;
   logic [WIDTH-1:0] dout_q, oe_q, otype_q, pol_q, pu_q, pd_q, mask_q;
   logic [WIDTH-1:0] pin_w, din_w;
   logic [BUS_W-1:0] rd_next;

   assign wr_any    = bus_req & bus_we;
   assign rd_any    = bus_req & ~bus_we;
   assign wr_lock_a = wr_any && (bus_addr == REG_LOCK_A);
   assign wr_lock_b = wr_any && (bus_addr == REG_LOCK_B);
   assign wr_ctrl   = wr_any & ~locked;

   gpio_lock_ctrl #(
      .KEY_ARM (KEY_ARM),
      .KEY_OPEN(KEY_OPEN)
   ) i_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_a  (wr_lock_a),
      .wr_b  (wr_lock_b),
      .wdata (bus_wdata),
      .locked(locked)
   );

   gpio_ctrl_regs #(
      .WIDTH(WIDTH)
   ) i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_ctrl),
      .addr   (bus_addr),
      .wdata  (bus_wdata[WIDTH-1:0]),
      .dout_q (dout_q),
      .oe_q   (oe_q),
      .otype_q(otype_q),
      .pol_q  (pol_q),
      .pu_q   (pu_q),
      .pd_q   (pd_q),
      .mask_q (mask_q)
   );

   gpio_pad_resolve #(
      .WIDTH         (WIDTH),
      .HAS_OPEN_DRAIN(HAS_OPEN_DRAIN)
   ) i_pad (
      .dout (dout_q),
      .oe   (oe_q),
      .otype(otype_q),
      .pol  (pol_q),
      .pu   (pu_q),
      .pd   (pd_q),
      .mask (mask_q),
      .pin  (pin_w),
      .din  (din_w)
   );

   always_comb begin
      rd_next = '0;
      case (reg_sel_e'(bus_addr))
         REG_LOCK_A: rd_next = BUS_W'(locked);
         REG_DIN:    rd_next = BUS_W'(din_w);
         REG_DOUT:   rd_next = BUS_W'(dout_q);
         REG_OE:     rd_next = BUS_W'(oe_q);
         REG_OTYPE:  rd_next = BUS_W'(otype_q);
         REG_POL:    rd_next = BUS_W'(pol_q);
         REG_PULLUP: rd_next = BUS_W'(pu_q);
         REG_PULLDN: rd_next = BUS_W'(pd_q);
         REG_INMASK: rd_next = BUS_W'(mask_q);
         default:    rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= rd_any;
         if (rd_any) bus_rdata <= rd_next;
      end
   end

endmodule

// File: rtl/gpio_pad_port_chk.sv
module gpio_pad_port_chk
   import gpio_pad_pkg::*;
#(
   parameter int               WIDTH    = 32,
   parameter logic [BUS_W-1:0] KEY_OPEN = 32'hC0DEFA73
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic              bus_rvalid,
   input logic              locked,
   input logic [WIDTH-1:0]  dout_q,
   input logic [WIDTH-1:0]  oe_q,
   input logic [WIDTH-1:0]  otype_q,
   input logic [WIDTH-1:0]  pol_q,
   input logic [WIDTH-1:0]  pu_q,
   input logic [WIDTH-1:0]  pd_q,
   input logic [WIDTH-1:0]  mask_q,
   input logic [WIDTH-1:0]  pin_w,
   input logic [WIDTH-1:0]  din_w
);

   assert_pushpull_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_w ^ dout_q ^ pol_q) & oe_q & ~otype_q) == '0);

   assert_od_pull_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q & otype_q & ~(dout_q ^ pol_q) & pin_w) == '0);

   assert_masked_reads_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((din_w ^ pol_q) & ~mask_q) == '0);

   assert_lock_b_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == REG_LOCK_B) |=> locked);

   assert_unlock_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(bus_req && bus_we && bus_addr == REG_LOCK_A && bus_wdata == KEY_OPEN));

   assert_locked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> ($stable(dout_q) && $stable(oe_q) && $stable(otype_q) && $stable(pol_q)
                  && $stable(pu_q) && $stable(pd_q) && $stable(mask_q)));

   assert_read_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> bus_rvalid);

   assert_write_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> !bus_rvalid);

endmodule

bind gpio_pad_port gpio_pad_port_chk #(
   .WIDTH   (WIDTH),
   .KEY_OPEN(KEY_OPEN)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rvalid(bus_rvalid),
   .locked    (locked),
   .dout_q    (dout_q),
   .oe_q      (oe_q),
   .otype_q   (otype_q),
   .pol_q     (pol_q),
   .pu_q      (pu_q),
   .pd_q      (pd_q),
   .mask_q    (mask_q),
   .pin_w     (pin_w),
   .din_w     (din_w)
);

// File: tb/test_gpio_pad_port.sv
`timescale 1ns/1ps
module test_gpio_pad_port;

   localparam logic [3:0] A_LOCK = 4'd0,  A_DIN = 4'd1,  A_DOUT = 4'd2,  A_DSET = 4'd3;
   localparam logic [3:0] A_DCLR = 4'd4,  A_OE = 4'd5,   A_OSET = 4'd6,  A_OCLR = 4'd7;
   localparam logic [3:0] A_OTYP = 4'd8,  A_POL = 4'd9,  A_PU = 4'd10,   A_PD = 4'd11;
   localparam logic [3:0] A_MASK = 4'd12, A_KEYB = 4'd13, A_NONE = 4'd14;
   localparam logic [31:0] K_ARM = 32'hC0DE1248, K_OPEN = 32'hC0DEFA73;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rvalid;
   logic [31:0] bus_rdata;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] pop_e;
   string       pop_t;

   // reference model state, built from the requirements
   logic [31:0] m_dout, m_oe, m_otyp, m_pol, m_pu, m_pd, m_mask;
   int          m_lock;  // 0 open, 1 shut, 2 armed

   always #5 clk = ~clk;

   gpio_pad_port i_gpio_pad_port (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
   );

   function automatic logic [31:0] model_din();
      logic [31:0] outv, drv, pin;
      outv = m_dout ^ m_pol;
      drv  = m_oe & (~m_otyp | ~outv);
      pin  = (drv & outv) | (~drv & m_pu & ~m_pd);
      return (pin & m_mask) ^ m_pol;
   endfunction

   function automatic logic [31:0] model_read(input logic [3:0] a);
      case (a)
         A_LOCK: return (m_lock != 0) ? 32'd1 : 32'd0;
         A_DIN:  return model_din();
         A_DOUT: return m_dout;
         A_OE:   return m_oe;
         A_OTYP: return m_otyp;
         A_POL:  return m_pol;
         A_PU:   return m_pu;
         A_PD:   return m_pd;
         A_MASK: return m_mask;
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_write(input logic [3:0] a, input logic [31:0] d);
      if (a == A_KEYB) m_lock = (d == K_ARM) ? 2 : 1;
      else if (a == A_LOCK) m_lock = (m_lock == 2 && d == K_OPEN) ? 0 : 1;
      else if (m_lock == 0) begin
         case (a)
            A_DOUT: m_dout = d;
            A_DSET: m_dout = m_dout | d;
            A_DCLR: m_dout = m_dout & ~d;
            A_OE:   m_oe = d;
            A_OSET: m_oe = m_oe | d;
            A_OCLR: m_oe = m_oe & ~d;
            A_OTYP: m_otyp = d;
            A_POL:  m_pol = d;
            A_PU:   m_pu = d;
            A_PD:   m_pd = d;
            A_MASK: m_mask = d;
            default: ;
         endcase
      end
   endtask

   // driver: one write, then check that no response follows (R11)
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      model_write(a, d);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
      checks++;
      if (bus_rvalid !== 1'b0) begin
         errors++;
         $display("FAIL R11 write response actual %b expected 0", bus_rvalid);
      end
   endtask

   // driver: push expected item, issue read
   task automatic rd(input logic [3:0] a, input string tag);
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
   endtask

   // monitor: pop and compare each response
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R11 unexpected response actual %h expected none", bus_rdata);
         end else begin
            pop_e = exp_q.pop_front();
            pop_t = tag_q.pop_front();
            if (bus_rdata !== pop_e) begin
               errors++;
               $display("FAIL %s actual %h expected %h", pop_t, bus_rdata, pop_e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_dout = '0; m_oe = '0; m_otyp = '0; m_pol = '0;
      m_pu = '1; m_pd = '0; m_mask = '1; m_lock = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      rd(A_LOCK, "R10 lock"); rd(A_DOUT, "R10 dout"); rd(A_OE, "R10 oe");
      rd(A_OTYP, "R10 otype"); rd(A_POL, "R10 pol"); rd(A_PU, "R10 pullup");
      rd(A_PD, "R10 pulldn"); rd(A_MASK, "R10 mask"); rd(A_DIN, "R10 din");
      rd(A_NONE, "R11 unmapped"); rd(A_DSET, "R11 alias reads 0");

      // R1 push-pull
      wr(A_OE, 32'hFFFF_FFFF); wr(A_PU, 32'hFFFF_0000); wr(A_PD, 32'h0000_FFFF);
      wr(A_DOUT, 32'h1357_2468);
      rd(A_DOUT, "R1 dout"); rd(A_DIN, "R1 din push-pull");

      // R3 pulls on undriven pins
      wr(A_OE, 32'h0); wr(A_DOUT, 32'hFFFF_0000);
      wr(A_PU, 32'h2468_ACE1); wr(A_PD, ~32'h2468_ACE1);
      rd(A_DIN, "R3 din pulls");

      // R4 both pulls or neither read 0
      wr(A_PU, 32'h00FF_00FF); wr(A_PD, 32'h0F0F_0F0F);
      rd(A_DIN, "R4 din conflicting pulls");

      // R6 set and clear aliases
      wr(A_DOUT, 32'hFFFF_FFFF); wr(A_PU, 32'h0); wr(A_PD, 32'hFFFF_FFFF);
      wr(A_OE, 32'h5A5A_5A5A);
      rd(A_DIN, "R6 din oe");
      wr(A_OCLR, 32'h0003_0002);
      rd(A_OE, "R6 oe clear"); rd(A_DIN, "R6 din after clear");
      wr(A_OSET, 32'h0000_F001);
      rd(A_OE, "R6 oe set"); rd(A_DIN, "R6 din after set");
      wr(A_DCLR, 32'h0F0F_0000); wr(A_DSET, 32'h0000_0011);
      rd(A_DOUT, "R6 dout aliases");

      // R2 open drain
      wr(A_OTYP, 32'h3C3C_5A5A); wr(A_OE, 32'hFF00_FF00); wr(A_DOUT, 32'hF0F0_F0F0);
      wr(A_PU, 32'hFFFF_0000); wr(A_PD, 32'h0000_FFFF);
      rd(A_OTYP, "R2 otype"); rd(A_DIN, "R2 din open-drain");

      // R1/R5 polarity on both paths
      wr(A_OTYP, 32'h0); wr(A_OE, 32'hFFFF_FFFF); wr(A_DOUT, 32'h2B2B_1C1C);
      wr(A_POL, 32'h6A6A_5555);
      rd(A_POL, "R1 pol"); rd(A_DIN, "R1 din polarity round trip");
      wr(A_OE, 32'h0); wr(A_POL, 32'hFFFF_FFFF);
      wr(A_PU, 32'h789A_BCDE); wr(A_PD, ~32'h789A_BCDE);
      rd(A_DIN, "R5 din inverted pulls");
      wr(A_OTYP, 32'hFFFF_FFFF); wr(A_OE, 32'hFFFF_FFFF);
      wr(A_PU, 32'hFFFF_0000); wr(A_PD, 32'h0000_FFFF); wr(A_DOUT, 32'hFF00_FF00);
      rd(A_DIN, "R2 din open-drain inverted");

      // R5 input mask
      wr(A_OTYP, 32'h0); wr(A_DOUT, 32'hFF00_FF00); wr(A_POL, 32'hFFFF_0000);
      wr(A_MASK, 32'h8142_2418);
      rd(A_DIN, "R5 din masked");

      // R7 R8 R9 lock
      wr(A_MASK, 32'hFFFF_FFFF); wr(A_POL, 32'h0); wr(A_DOUT, 32'h1111_2222);
      rd(A_LOCK, "R7 unlocked status");
      wr(A_LOCK, 32'h0);
      rd(A_LOCK, "R7 locked status");
      wr(A_DOUT, 32'h3333_4444); wr(A_OCLR, 32'hFFFF_FFFF); wr(A_PU, 32'h0);
      wr(A_MASK, 32'h0);
      rd(A_DOUT, "R9 dout kept"); rd(A_OE, "R9 oe kept"); rd(A_PU, "R9 pullup kept");
      rd(A_DIN, "R9 din readable");
      wr(A_LOCK, K_OPEN); wr(A_KEYB, K_ARM);
      rd(A_LOCK, "R8 reversed keys stay locked");
      wr(A_LOCK, 32'h1234_5678);
      rd(A_LOCK, "R8 wrong final key");
      wr(A_KEYB, K_ARM); wr(A_DOUT, 32'h5555_6666);
      rd(A_DOUT, "R9 armed write ignored");
      wr(A_LOCK, K_OPEN);
      rd(A_LOCK, "R8 unlocked");
      wr(A_DOUT, 32'h7777_8888);
      rd(A_DOUT, "R8 write after unlock");
      wr(A_KEYB, 32'h0);
      rd(A_LOCK, "R7 second lock register closes");
      wr(A_DSET, 32'hFFFF_FFFF);
      rd(A_DOUT, "R9 set alias ignored");
      wr(A_KEYB, K_ARM); wr(A_LOCK, K_OPEN);
      rd(A_LOCK, "R8 unlocked again");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R11 missing responses actual %0d expected 0", exp_q.size());
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule